// File: doc/BRIEF.md
# Nine-Lane Residue-to-Binary Reconstructor

This block takes a residue vector over the coprime base {7, 11, 13, 15, 17, 19, 23, 29, 31} and returns the unique integer x in [0, M−1] that has those residues. M, the product of the base, is 100,280,245,065. The block forms x with the Chinese Remainder Theorem. Each lane has a constant table, and the table maps a residue r to a weighted term (r·K) mod M. Here K = (M/m)·((M/m)⁻¹ mod m) is fixed for the lane. The nine terms are added, and the total is brought back below M by a short chain of compare-and-subtract steps. No divider is used. The same result is also presented as a two's-complement value: any x at or above (M+1)/2 is shown as x − M.

It sits at the end of a residue-arithmetic datapath. The residue producer drives a valid/ready pair on the input side, and the binary consumer drives a valid/ready pair on the output side. The lane tables are built at elaboration from the base, with the modular inverses found by search.

The pipeline has three registered stages and no state machine. The stages are lane lookup (LOOKUP), tree sum (SUM) and fold-and-present (PRESENT). Each stage holds one valid flag. A single advance condition moves all three stages forward together. The transitions are therefore limited to ADVANCE, where every stage shifts by one position, and HOLD, where every stage keeps its contents.

Top module: `crt_reconstruct`

## Requirements
- R1: While reset is applied and in the first cycle after release, out_valid is 0 and in_ready is 1.
- R2: For any x in [0, M−1], presenting the residues (x mod mᵢ) returns out_uns = x exactly. Lane i occupies in_res bits [5i+4:5i], and the lane order is 7, 11, 13, 15, 17, 19, 23, 29, 31.
- R3: With out_ready held at 1, an item accepted at clock edge E appears with out_valid = 1 after edge E+2 (three register stages). The block accepts one new item on every cycle.
- R4: A residue code at or above its lane's modulus adds zero to the sum. For example, codes 7..31 in lane 0 behave like residue 0.
- R5: out_uns is always below M. The all-maximum residue vector (mᵢ−1 in every lane) returns M−1.
- R6: out_sgn is 38-bit two's complement. It equals out_uns when out_uns < (M+1)/2 = 50,140,122,533, and out_uns − M otherwise. So 50,140,122,532 stays positive and 50,140,122,533 gives −50,140,122,532.
- R7: While out_valid = 1 and out_ready = 0, the outputs hold steady and in_ready is 0. No item is lost or repeated.
- R8: Whenever out_valid is 0, in_ready is 1.
- R9: An all-zero residue vector returns 0 on both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Residue vector is present |
| in_ready | output | 1 | Block takes the vector on this edge |
| in_res | input | 45 | Nine 5-bit residue codes, lane 0 in the low bits |
| out_valid | output | 1 | Reconstructed value is present |
| out_ready | input | 1 | Consumer takes the value on this edge |
| out_uns | output | 37 | Reconstructed unsigned value |
| out_sgn | output | 38 | Same value in signed view |

## Verification
An accepted vector reaches the output registers after three rising edges, provided the consumer never stalls. The bench checks this in a directed test: it samples out_valid low at the falling edges between acceptance and the third edge, then samples it high with the value. Every other result is checked through an expectation queue. An entry is pushed at the falling edge before each accepting edge and popped at the falling edge before each output-taking edge. The check therefore holds under any stall pattern. During a stall, the held values and the deasserted in_ready are compared against the previous falling-edge sample.

// File: rtl/crt_pkg.sv
package crt_pkg;

    // Residue base shared by the whole reconstructor
    localparam int NCH   = 9;
    localparam int RES_W = 5;
    localparam int unsigned MODULI [NCH] = '{7, 11, 13, 15, 17, 19, 23, 29, 31};

    function automatic longint unsigned base_product();
        longint unsigned p;
        p = 1;
        for (int i = 0; i < NCH; i++) begin
            p = p * longint'(MODULI[i]);
        end
        return p;
    endfunction

    localparam longint unsigned CRT_M  = base_product();
    localparam int              WORD_W = $clog2(CRT_M);
    localparam int              SUM_W  = $clog2(CRT_M * longint'(NCH));
    localparam int              FOLD_STEPS = $clog2(NCH);
    localparam int              SGN_W  = WORD_W + 1;

    // Multiplicative inverse of a modulo m, found by linear search
    function automatic longint unsigned inverse_of(longint unsigned a, longint unsigned m);
        longint unsigned found;
        found = 0;
        for (longint unsigned n = 1; n < m; n++) begin
            if (((a % m) * n) % m == 1) found = n;
        end
        return found;
    endfunction

    // CRT weight of one lane: (M/m * inverse) mod M
    function automatic longint unsigned lane_weight(int idx);
        longint unsigned m;
        longint unsigned part;
        m    = longint'(MODULI[idx]);
        part = CRT_M / m;
        return (part * inverse_of(part, m)) % CRT_M;
    endfunction

endpackage

// File: rtl/crt_lane_rom.sv
module crt_lane_rom #(
    parameter int              RES_W   = 5,
    parameter int              WORD_W  = 37,
    parameter int unsigned     MODULUS = 7,
    parameter longint unsigned WEIGHT  = 1,
    parameter longint unsigned CRT_M   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RES_W-1:0]  res,
    output logic [WORD_W-1:0] term
);

    localparam int DEPTH = 1 << RES_W;

    typedef logic [DEPTH-1:0][WORD_W-1:0] table_t;

    // Codes at or above the modulus carry zero weight
    function automatic table_t fill_table();
        table_t t;
        for (int r = 0; r < DEPTH; r++) begin
            if (r < int'(MODULUS)) begin
                t[r] = WORD_W'((longint'(r) * WEIGHT) % CRT_M);
            end else begin
                t[r] = '0;
            end
        end
        return t;
    endfunction

    localparam table_t LANE_TABLE = fill_table();

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term <= '0;
        end else if (en) begin
            term <= LANE_TABLE[res];
        end
    end

endmodule

// File: rtl/crt_add_tree.sv
module crt_add_tree #(
    parameter int N     = 9,
    parameter int IN_W  = 37,
    parameter int OUT_W = 40
) (
    input  logic [N-1:0][IN_W-1:0] leaf,
    output logic [OUT_W-1:0]       total
);

    localparam int LEAVES = 1 << $clog2(N);

    // Heap-indexed balanced tree: node k sums nodes 2k and 2k+1
    logic [2*LEAVES-1:1][OUT_W-1:0] node;

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N) begin : g_used
            assign node[LEAVES+i] = OUT_W'(leaf[i]);
        end else begin : g_pad
            assign node[LEAVES+i] = '0;
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        assign node[k] = node[2*k] + node[2*k+1];
    end

    assign total = node[1];

endmodule

// File: rtl/crt_mod_fold.sv
module crt_mod_fold #(
    parameter int              SUM_W  = 40,
    parameter int              WORD_W = 37,
    parameter int              STEPS  = 4,
    parameter longint unsigned CRT_M  = 7
) (
    input  logic [SUM_W-1:0]  sum,
    output logic [WORD_W-1:0] value
);

    // chain[STEPS] is the raw sum; each step removes (M << k) when possible
    logic [STEPS:0][SUM_W-1:0] chain;

    assign chain[STEPS] = sum;

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        localparam logic [SUM_W-1:0] STEP_VAL = SUM_W'(CRT_M << k);
        assign chain[k] = (chain[k+1] >= STEP_VAL) ? (chain[k+1] - STEP_VAL) : chain[k+1];
    end

    assign value = WORD_W'(chain[0]);

endmodule

// File: rtl/crt_reconstruct.sv
module crt_reconstruct
    import crt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [NCH*RES_W-1:0]   in_res,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [WORD_W-1:0]      out_uns,
    output logic [SGN_W-1:0]       out_sgn
);

    localparam longint unsigned HALF = (CRT_M + 1) / 2;

    logic                        advance;
    logic                        lookup_v;
    logic                        sum_v;
    logic [NCH-1:0][WORD_W-1:0]  terms;
    logic [SUM_W-1:0]            tree_sum;
    logic [SUM_W-1:0]            sum_q;
    logic [WORD_W-1:0]           folded;
    logic [SGN_W-1:0]            sgn_next;

    // Whole pipeline moves when the output slot is free or being taken
    assign advance  = !out_valid || out_ready;
    assign in_ready = advance;

    // Stage LOOKUP: one constant table per lane
    for (genvar g = 0; g < NCH; g++) begin : g_lane
        crt_lane_rom #(
            .RES_W   (RES_W),
            .WORD_W  (WORD_W),
            .MODULUS (MODULI[g]),
            .WEIGHT  (lane_weight(g)),
            .CRT_M   (CRT_M)
        ) u_rom (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (advance),
            .res   (in_res[g*RES_W +: RES_W]),
            .term  (terms[g])
        );
    end

    // Stage SUM
    crt_add_tree #(
        .N     (NCH),
        .IN_W  (WORD_W),
        .OUT_W (SUM_W)
    ) u_tree (
        .leaf  (terms),
        .total (tree_sum)
    );

    // Stage PRESENT: fold below M and form the signed view
    crt_mod_fold #(
        .SUM_W  (SUM_W),
        .WORD_W (WORD_W),
        .STEPS  (FOLD_STEPS),
        .CRT_M  (CRT_M)
    ) u_fold (
        .sum   (sum_q),
        .value (folded)
    );

    always_comb begin
        if (folded >= WORD_W'(HALF)) begin
            sgn_next = {1'b0, folded} - SGN_W'(CRT_M);
        end else begin
            sgn_next = {1'b0, folded};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lookup_v  <= 1'b0;
            sum_v     <= 1'b0;
            out_valid <= 1'b0;
        end else if (advance) begin
            lookup_v  <= in_valid;
            sum_v     <= lookup_v;
            out_valid <= sum_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            out_uns <= '0;
            out_sgn <= '0;
        end else if (advance) begin
            sum_q   <= tree_sum;
            out_uns <= folded;
            out_sgn <= sgn_next;
        end
    end

endmodule

// File: rtl/crt_reconstruct_chk.sv
module crt_reconstruct_chk
    import crt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_uns,
    input logic [SGN_W-1:0]  out_sgn
);

    localparam longint unsigned HALF = (CRT_M + 1) / 2;

    a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_uns) && $stable(out_sgn)));

    a_r7_no_accept_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    a_r5_result_below_m: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_uns < WORD_W'(CRT_M)));

    a_r6_signed_matches_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((out_uns >= WORD_W'(HALF)) == out_sgn[SGN_W-1]) &&
                       (WORD_W'(out_sgn + (out_sgn[SGN_W-1] ? SGN_W'(CRT_M) : SGN_W'(0))) == out_uns)));

endmodule

bind crt_reconstruct crt_reconstruct_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_uns   (out_uns),
    .out_sgn   (out_sgn)
);

// File: tb/tb_crt_reconstruct.sv
module tb_crt_reconstruct;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NL = 9;
    localparam int RW = 5;
    localparam int UW = 37;
    localparam int SW = 38;
    localparam longint unsigned MODV [NL] = '{7, 11, 13, 15, 17, 19, 23, 29, 31};
    localparam longint unsigned MTOT  = 64'd100280245065;
    localparam longint unsigned HALFV = (MTOT + 1) / 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [NL*RW-1:0]  in_res;
    logic              out_valid;
    logic              out_ready;
    logic [UW-1:0]     out_uns;
    logic [SW-1:0]     out_sgn;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int bp_mode = 0;
    logic [15:0] bp_lfsr = 16'hACE1;
    longint unsigned expq [$];
    longint unsigned exp_in = 0;
    longint unsigned seed = 64'h9E3779B97F4A7C15;
    bit prev_stall = 1'b0;
    logic [UW-1:0] prev_uns;
    logic [SW-1:0] prev_sgn;

    always #2 clk = ~clk;

    crt_reconstruct dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_res    (in_res),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_uns   (out_uns),
        .out_sgn   (out_sgn)
    );

    function automatic logic [NL*RW-1:0] encode(longint unsigned x);
        logic [NL*RW-1:0] r;
        for (int i = 0; i < NL; i++) r[i*RW +: RW] = RW'(x % MODV[i]);
        return r;
    endfunction

    function automatic longint signed signed_of(longint unsigned x);
        if (x >= HALFV) return longint'(x) - longint'(MTOT);
        return longint'(x);
    endfunction

    task automatic check(input bit ok, input string tag, input longint signed act, input longint signed expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Called just after a rising edge; returns just after the accepting edge
    task automatic push(input logic [NL*RW-1:0] res, input longint unsigned x);
        in_res   = res;
        exp_in   = x;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic longint unsigned next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    // Output consumer: always ready, or a pseudo-random stall pattern
    always @(posedge clk) begin
        #1;
        bp_lfsr = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
        if (bp_mode == 0) out_ready = 1'b1;
        else out_ready = bp_lfsr[0] | bp_lfsr[3];
    end

    // Scoreboard: sampled between edges
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (prev_stall) begin
                check(out_valid && out_uns == prev_uns && out_sgn == prev_sgn,
                      "R7 held output", longint'(out_uns), longint'(prev_uns));
            end
            if (out_valid && !out_ready) begin
                check(!in_ready, "R7 in_ready low while stalled", longint'(in_ready), 0);
                prev_stall = 1'b1;
                prev_uns   = out_uns;
                prev_sgn   = out_sgn;
            end else begin
                prev_stall = 1'b0;
            end
            if (!out_valid) begin
                check(in_ready, "R8 ready when empty", longint'(in_ready), 1);
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R7 output with no pending item", longint'(out_uns), -1);
                end else begin
                    longint unsigned e;
                    e = expq.pop_front();
                    check(longint'(out_uns) == longint'(e), "R2 round trip value",
                          longint'(out_uns), longint'(e));
                    check(out_uns < UW'(MTOT), "R5 below M", longint'(out_uns), longint'(MTOT) - 1);
                    check(longint'($signed(out_sgn)) == signed_of(e), "R6 signed view",
                          longint'($signed(out_sgn)), signed_of(e));
                end
            end
            if (in_valid && in_ready) expq.push_back(exp_in);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [NL*RW-1:0] r;
        longint unsigned x;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_res    = '0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R1 out_valid low in reset", longint'(out_valid), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 idle after reset", longint'({out_valid, in_ready}), 1);
        @(posedge clk);
        #1;

        // R3: exact latency of three edges
        push(encode(64'd12345), 64'd12345);
        @(negedge clk);
        check(!out_valid, "R3 not yet after first edge", longint'(out_valid), 0);
        @(negedge clk);
        check(!out_valid, "R3 not yet after second edge", longint'(out_valid), 0);
        @(negedge clk);
        check(out_valid && out_uns == UW'(64'd12345), "R3 due after third edge",
              longint'(out_uns), 12345);
        @(posedge clk);
        #1;

        // R9: all-zero vector
        push('0, 64'd0);
        repeat (4) @(posedge clk);
        #1;

        // R2/R3: low sweep, back to back
        for (int k = 0; k < 256; k++) push(encode(longint'(k)), longint'(k));
        // R5: top of range, including the all-maximum vector (M-1)
        for (int k = 0; k < 64; k++) push(encode(MTOT - 1 - longint'(k)), MTOT - 1 - longint'(k));
        // R6: around the signed boundary
        for (int k = -32; k < 32; k++) push(encode(HALFV + longint'(k)), HALFV + longint'(k));

        // R4: out-of-range codes in lane 0 (mod 7) and lane 3 (mod 15)
        x = 64'd7 * 64'd1000003;
        for (int c = 7; c < 32; c++) begin
            r = encode(x);
            r[0 +: RW] = RW'(c);
            push(r, x);
        end
        x = 64'd15 * 64'd2000003;
        for (int c = 15; c < 32; c++) begin
            r = encode(x);
            r[3*RW +: RW] = RW'(c);
            push(r, x);
        end

        // R7: random values under stall pattern with input gaps
        bp_mode = 1;
        for (int k = 0; k < 1500; k++) begin
            x = next_rand() % MTOT;
            push(encode(x), x);
            if (next_rand() % 4 == 0) begin
                @(posedge clk);
                #1;
            end
        end
        bp_mode = 0;

        // Drain
        for (int k = 0; k < 200 && (expq.size() != 0 || out_valid); k++) @(posedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R7 every item delivered", longint'(expq.size()), 0);
        summary();
        $finish;
    end

endmodule